// File: doc/BRIEF.md
# Write-Protected Watchdog NMI Controller

This block sits on a byte-wide register bus and decides whether a watchdog expiry becomes a non-maskable interrupt. A free-running 16-bit up-counter is compared every cycle with a programmable compare value. When the two are equal the counter wraps to zero, and if the NMI enable bit is set, a one-cycle NMI pulse is issued. Software keeps the watchdog quiet by writing the service register, which clears the counter before it reaches the compare value.

The NMI enable bit is guarded by a small lock state machine with two states, LOCKED and OPEN. The transition UNLOCK (LOCKED to OPEN) happens when software writes 1 to the key bit. There are two transitions from OPEN back to LOCKED. CONSUME happens when the enable register is written: that write is applied. RELOCK happens when 0 is written to the key bit. Each unlock therefore admits exactly one write to the enable bit. Clearing the enable bit only masks the NMI. The counter keeps running and matching, so a later re-enable picks up the old count phase unless the counter is serviced first.

Register map, with byte offsets from the base address `BASE` (default 0x40170). Offset 0 is the key register, with its key bit at bit 7. Offset 1 is the enable register, with its enable bit at bit 1. Offsets 2 and 3 hold the compare value, low byte then high byte. Offset 4 is the service register, which acts only as a write strobe. Reads are combinational on the address and take effect in the same cycle.

Top module: `wdog_nmi_ctrl`

## Requirements
- R1: After reset the key bit and the enable bit are 0, both control registers read 0x00 and `nmi_o` is 0.
- R2: Writing a byte with bit 7 set to offset 0 moves the lock to OPEN, and offset 0 then reads 0x80. Bits 6..0 of offset 0 always read 0.
- R3: Writing a byte with bit 7 clear to offset 0 while OPEN returns the lock to LOCKED, and a following enable write is ignored.
- R4: A write to offset 1 while OPEN loads wdata bit 1 into the enable bit and returns the lock to LOCKED in the same cycle. A second write without a new unlock has no effect.
- R5: A write to offset 1 while LOCKED leaves the enable bit unchanged.
- R6: Offset 1 reads the enable bit at bit 1 and 0 in every other bit. The service offset and any address outside offsets 0..4 read 0x00.
- R7: The compare value is written and read back as a low byte at offset 2 and a high byte at offset 3, and it resets to 0xFFFF.
- R8: The counter starts at 0 and advances by one each cycle. In a cycle where it equals the compare value, it wraps to 0 on the next edge, giving a period of compare+1 cycles.
- R9: When a match occurs while the enable bit is 1, `nmi_o` is high for exactly the following cycle.
- R10: While the enable bit is 0, matches produce no NMI, but the counter keeps counting and wrapping.
- R11: A write to offset 4 clears the counter to 0 on that edge, and this takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (20) | Byte address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on `bus_addr` |
| nmi_o | output | 1 | One-cycle NMI pulse |

## Verification
Read data is due in the same cycle as the address. The bench therefore drives the address at the falling edge and samples `bus_rdata` 1 ns later, before any edge can occur. Register writes and counter clears take effect at the next rising edge. `nmi_o` rises one edge after the match cycle, because the match is registered once. The bench's cycle model advances at every rising edge, and `nmi_o` is compared 1 ns after that edge, so each expected pulse is checked in the exact cycle it should appear and every other cycle is checked for absence.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;
    localparam int unsigned OFS_KEY = 0;
    localparam int unsigned OFS_EN  = 1;
    localparam int unsigned OFS_CMP = 2;
    localparam int unsigned KEY_BIT = 7;
    localparam int unsigned EN_BIT  = 1;

    typedef enum logic {
        LK_LOCKED = 1'b0,
        LK_OPEN   = 1'b1
    } lock_state_t;
endpackage

// File: rtl/wdog_bus_decode.sv
`timescale 1ns/1ps
module wdog_bus_decode #(
    parameter int unsigned       ADDR_W = 20,
    parameter int unsigned       NREG   = 5,
    parameter logic [ADDR_W-1:0] BASE   = 20'h40170
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic [NREG-1:0]   sel,
    output logic [NREG-1:0]   we
);
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE + ADDR_W'(i);
        assign sel[i] = (addr == SLOT_ADDR);
        assign we[i]  = sel[i] & wr;
    end
endmodule

// File: rtl/wdog_lock_fsm.sv
`timescale 1ns/1ps
module wdog_lock_fsm
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_we,
    input  logic key_bit,
    input  logic en_we,
    input  logic en_bit,
    output logic key_o,
    output logic en_o
);
    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOCKED;
        else        state_q <= state_d;
    end

    // transitions: UNLOCK, CONSUME, RELOCK
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_LOCKED: if (key_we && key_bit) state_d = LK_OPEN;
            LK_OPEN:   if (en_we || (key_we && !key_bit)) state_d = LK_LOCKED;
            default:   state_d = LK_LOCKED;
        endcase
    end

    // outputs: enable bit is loaded only by the write that consumes an unlock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            en_o <= 1'b0;
        else if (state_q == LK_OPEN && en_we)  en_o <= en_bit;
    end

    assign key_o = (state_q == LK_OPEN);
endmodule

// File: rtl/wdog_cmp_timer.sv
`timescale 1ns/1ps
module wdog_cmp_timer #(
    parameter int unsigned        CNT_W     = 16,
    parameter logic [CNT_W-1:0]   CMP_RESET = '1,
    localparam int unsigned       NB        = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NB-1:0]    cmp_we,
    input  logic [7:0]       wdata,
    input  logic             svc,
    output logic [CNT_W-1:0] cmp_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             match_o
);
    logic [CNT_W-1:0] cnt_q;

    for (genvar b = 0; b < NB; b++) begin : g_cmp_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         cmp_o[8*b +: 8] <= CMP_RESET[8*b +: 8];
            else if (cmp_we[b]) cmp_o[8*b +: 8] <= wdata;
        end
    end

    assign match_o = (cnt_q == cmp_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (svc || match_o)   cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdog_nmi_ctrl.sv
`timescale 1ns/1ps
module wdog_nmi_ctrl
    import wdog_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 20,
    parameter logic [ADDR_W-1:0]  BASE      = 20'h40170,
    parameter int unsigned        CNT_W     = 16,
    parameter logic [CNT_W-1:0]   CMP_RESET = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              nmi_o
);
    localparam int unsigned NB      = CNT_W / 8;
    localparam int unsigned OFS_SVC = OFS_CMP + NB;
    localparam int unsigned NREG    = OFS_SVC + 1;

    logic [NREG-1:0]  sel, we;
    logic [NB-1:0]    cmp_we;
    logic [CNT_W-1:0] cmp_q, cnt_w;
    logic             key_q, en_q, match, key_we, en_we, svc_we;

    wdog_bus_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .BASE(BASE)) u_dec (
        .addr(bus_addr), .wr(bus_wr), .sel(sel), .we(we)
    );

    assign key_we = we[OFS_KEY];
    assign en_we  = we[OFS_EN];
    assign svc_we = we[OFS_SVC];

    for (genvar b = 0; b < NB; b++) begin : g_cmp_we
        assign cmp_we[b] = we[OFS_CMP + b];
    end

    wdog_lock_fsm u_lock (
        .clk(clk), .rst_n(rst_n),
        .key_we(key_we), .key_bit(bus_wdata[KEY_BIT]),
        .en_we(en_we),   .en_bit(bus_wdata[EN_BIT]),
        .key_o(key_q),   .en_o(en_q)
    );

    wdog_cmp_timer #(.CNT_W(CNT_W), .CMP_RESET(CMP_RESET)) u_timer (
        .clk(clk), .rst_n(rst_n), .cmp_we(cmp_we), .wdata(bus_wdata),
        .svc(svc_we), .cmp_o(cmp_q), .cnt_o(cnt_w), .match_o(match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nmi_o <= 1'b0;
        else        nmi_o <= match & en_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (sel[OFS_KEY]) bus_rdata[KEY_BIT] = key_q;
        if (sel[OFS_EN])  bus_rdata[EN_BIT]  = en_q;
        for (int b = 0; b < NB; b++) begin
            if (sel[OFS_CMP + b]) bus_rdata = cmp_q[8*b +: 8];
        end
    end
endmodule

// File: rtl/wdog_nmi_checker.sv
`timescale 1ns/1ps
module wdog_nmi_checker #(
    parameter int unsigned       CNT_W  = 16,
    parameter int unsigned       ADDR_W = 20,
    parameter logic [ADDR_W-1:0] BASE   = 20'h40170
) (
    input logic              clk,
    input logic              rst_n,
    input logic              key,
    input logic              en,
    input logic              key_we,
    input logic              key_bit,
    input logic              en_we,
    input logic              en_bit,
    input logic              svc_we,
    input logic              match,
    input logic [CNT_W-1:0]  cnt,
    input logic              nmi,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] EN_ADDR = BASE + ADDR_W'(1);

    a_r3_key_clear_relocks: assert property (@(posedge clk) disable iff (!rst_n)
        (key_we && !key_bit) |=> !key);
    a_r4_write_consumes_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (key && en_we) |=> !key);
    a_r4_write_loads_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (key && en_we) |=> (en == $past(en_bit)));
    a_r5_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!key && en_we) |=> $stable(en));
    a_r6_en_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == EN_ADDR) |-> (rdata[7:2] == 6'd0 && rdata[0] == 1'b0));
    a_r8_wrap_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> (cnt == '0));
    a_r8_count_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !svc_we) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    a_r9_nmi_on_enabled_match: assert property (@(posedge clk) disable iff (!rst_n)
        (match && en) |=> nmi);
    a_r10_no_nmi_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !(match && en) |=> !nmi);
    a_r11_service_clears: assert property (@(posedge clk) disable iff (!rst_n)
        svc_we |=> (cnt == '0));
endmodule

bind wdog_nmi_ctrl wdog_nmi_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .key(key_q), .en(en_q),
    .key_we(key_we), .key_bit(bus_wdata[7]), .en_we(en_we), .en_bit(bus_wdata[1]),
    .svc_we(svc_we), .match(match), .cnt(cnt_w), .nmi(nmi_o),
    .addr(bus_addr), .rdata(bus_rdata)
);

// File: tb/tb_wdog_nmi_ctrl.sv
`timescale 1ns/1ps
module tb_wdog_nmi_ctrl;
    localparam logic [19:0] BASE = 20'h40170;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] addr = BASE;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        nmi;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    // bench model of the register and timer state
    logic        m_key, m_en, m_nmi;
    logic [15:0] m_cmp, m_cnt;

    always #5 clk = ~clk;

    wdog_nmi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .nmi_o(nmi)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] mread(input logic [19:0] a);
        logic [7:0] v = '0;
        if (a == BASE)                 v[7] = m_key;
        else if (a == BASE + 20'd1)    v[1] = m_en;
        else if (a == BASE + 20'd2)    v = m_cmp[7:0];
        else if (a == BASE + 20'd3)    v = m_cmp[15:8];
        return v;
    endfunction

    function automatic string req_of(input logic [19:0] a);
        if (a == BASE)              return "R2";
        if (a == BASE + 20'd1)      return "R4";
        if (a == BASE + 20'd2 || a == BASE + 20'd3) return "R7";
        if (a == BASE + 20'd4)      return "R11";
        return "R6";
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [19:0] a, input logic w, input logic [7:0] d, input string req);
        logic match;
        addr = a; wr = w; wdata = d;
        #1;
        chk((req == "") ? req_of(a) : req, rdata, mread(a));
        match = (m_cnt == m_cmp);
        @(posedge clk);
        m_nmi = match & m_en;
        if (w && a == BASE + 20'd4) m_cnt = '0;
        else if (match)             m_cnt = '0;
        else                        m_cnt = m_cnt + 16'd1;
        if (w) begin
            if (a == BASE) m_key = d[7];
            else if (a == BASE + 20'd1) begin
                if (m_key) begin m_en = d[1]; m_key = 1'b0; end
            end
            else if (a == BASE + 20'd2) m_cmp[7:0]  = d;
            else if (a == BASE + 20'd3) m_cmp[15:8] = d;
        end
        #1;
        chk(m_nmi ? "R9" : "R10", {7'd0, nmi}, {7'd0, m_nmi});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(BASE + 20'd7, 1'b0, 8'h00, "R6");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog all act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        m_key = 0; m_en = 0; m_nmi = 0; m_cmp = 16'hFFFF; m_cnt = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        addr = BASE; #1; chk("R1", rdata, 8'h00);
        addr = BASE + 20'd1; #1; chk("R1", rdata, 8'h00);
        chk("R1", {7'd0, nmi}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: unlock and reserved bits
        step(BASE, 1'b1, 8'h80, "R2");
        step(BASE, 1'b0, 8'h00, "R2");
        step(BASE, 1'b1, 8'hFF, "R2");
        step(BASE, 1'b0, 8'h00, "R2");
        // R3: relock then enable write ignored
        step(BASE, 1'b1, 8'h00, "R3");
        step(BASE + 20'd1, 1'b1, 8'h02, "R3");
        step(BASE + 20'd1, 1'b0, 8'h00, "R3");
        // R5: locked enable write ignored
        step(BASE + 20'd1, 1'b1, 8'hFF, "R5");
        step(BASE + 20'd1, 1'b0, 8'h00, "R5");
        // R4: one write per unlock, consumes the key
        step(BASE, 1'b1, 8'h80, "R4");
        step(BASE + 20'd1, 1'b1, 8'hFF, "R4");
        step(BASE + 20'd1, 1'b0, 8'h00, "R4");
        step(BASE, 1'b0, 8'h00, "R4");
        step(BASE + 20'd1, 1'b1, 8'h00, "R4");
        step(BASE + 20'd1, 1'b0, 8'h00, "R4");
        // R7: compare readback, then R11 service and R8/R9 period of 10
        step(BASE + 20'd2, 1'b0, 8'h00, "R7");
        step(BASE + 20'd3, 1'b0, 8'h00, "R7");
        step(BASE + 20'd2, 1'b1, 8'h09, "R7");
        step(BASE + 20'd3, 1'b1, 8'h00, "R7");
        step(BASE + 20'd2, 1'b0, 8'h00, "R7");
        step(BASE + 20'd4, 1'b1, 8'hA5, "R11");
        idle(35);
        // R10: mask, keep counting, re-enable keeps phase
        step(BASE, 1'b1, 8'h80, "R10");
        step(BASE + 20'd1, 1'b1, 8'h00, "R10");
        idle(27);
        step(BASE, 1'b1, 8'h80, "R10");
        step(BASE + 20'd1, 1'b1, 8'h02, "R10");
        idle(23);
        // R11: regular service prevents any NMI
        for (int k = 0; k < 6; k++) begin
            step(BASE + 20'd4, 1'b1, 8'h00, "R11");
            idle(6);
        end
        // R6: unmapped reads
        step(BASE + 20'd5, 1'b0, 8'h00, "R6");
        step(BASE - 20'd1, 1'b0, 8'h00, "R6");
        step(20'h00000, 1'b0, 8'h00, "R6");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [19:0] a;
            logic [7:0]  d;
            r = int'($urandom % 16);
            d = 8'($urandom);
            if (r < 3)       a = BASE;
            else if (r < 6)  a = BASE + 20'd1;
            else if (r < 7)  begin a = BASE + 20'd2; d = 8'($urandom % 30); end
            else if (r < 8)  begin a = BASE + 20'd3; d = ($urandom % 8 == 0) ? 8'h01 : 8'h00; end
            else if (r < 9)  a = BASE + 20'd4;
            else if (r < 11) a = BASE + 20'd5;
            else             a = BASE + 20'(r);
            step(a, ($urandom % 3) != 0, d, "");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule